// File: doc/BRIEF.md
# I2C Bus Condition Sequencer

This block creates the framing conditions of an open-drain I2C bus: START, repeated START and STOP. It works through a fixed series of phases for each condition. Each phase holds the two lines in a set state for its own programmable number of functional-clock cycles. The six cycle counts come from configuration registers outside the block. Software typically derives them from the bus speed; at 100 kHz they correspond to roughly 4.4 to 5.2 us for the hold and setup intervals, and at 400 kHz to roughly 0.66 us.

Requests arrive as one-cycle strobes. A STOP or repeated START requested while the serial engine is still moving a frame waits until the engine reports idle. A START requested while the bus is occupied waits until the bus-free interval that follows a STOP has run out. The outputs are pull-down enables for SCL and SDA, where 1 means drive the line low and 0 means release it. The block also reports bus occupancy and sets two sticky completion flags, each cleared by a write strobe.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset both pull enables are 0, busy is 0 and both completion flags are 0.
- R2: A START pulls SDA while SCL is released for max(t_start_hold,1) cycles. It then pulls SCL low with SDA still pulled, which is the owned-bus state. A count of 0 always acts as 1.
- R3: busy is 1 from the first START cycle until the bus-free phase ends. A START strobe that arrives during the bus-free phase is held. It is followed by exactly one cycle with both lines released and busy 0, and then the START phase.
- R4: A STOP runs three phases. Both lines are pulled for max(t_data_setup,1) cycles. Then SCL is released with SDA pulled for max(t_stop_setup,1) cycles. Then both lines are released with busy 1 for max(t_bus_free,1) cycles.
- R5: A repeated START runs three phases. SCL is pulled with SDA released for max(t_data_setup,1) cycles. Then both lines are released for max(t_rs_setup,1) cycles. Then SDA is pulled with SCL released for max(t_rs_hold,1) cycles. After that the block returns to the owned-bus state.
- R6: A pending STOP or repeated START does not begin while shifter_idle is 0.
- R7: stop_flag goes to 1 in the first bus-free cycle and stays 1 until a clr_stop strobe. When a set and a clear fall in the same cycle, the set wins.
- R8: rstart_flag goes to 1 when the repeated-START hold phase ends, and stays 1 until a clr_rstart strobe.
- R9: STOP and repeated-START strobes that arrive while the bus is idle have no effect, either at that moment or after a later START.
- R10: When a STOP and a repeated START are both pending, the STOP runs and the repeated START is discarded.
- R11: In every cycle, at most one of the two pull enables changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t_start_hold | input | CW | START hold cycles |
| t_rs_hold | input | CW | Repeated-START hold cycles |
| t_rs_setup | input | CW | Repeated-START setup cycles |
| t_data_setup | input | CW | SDA setup cycles before SCL is released |
| t_stop_setup | input | CW | STOP setup cycles |
| t_bus_free | input | CW | Bus-free cycles after STOP |
| req_start | input | 1 | START request strobe |
| req_stop | input | 1 | STOP request strobe |
| req_rstart | input | 1 | Repeated-START request strobe |
| shifter_idle | input | 1 | Serial engine has no frame in flight |
| clr_stop | input | 1 | Clear strobe for stop_flag |
| clr_rstart | input | 1 | Clear strobe for rstart_flag |
| scl_pull | output | 1 | Drive SCL low |
| sda_pull | output | 1 | Drive SDA low |
| busy | output | 1 | Bus occupied |
| stop_flag | output | 1 | Sticky STOP-complete flag |
| rstart_flag | output | 1 | Sticky repeated-START-complete flag |

## Verification
The bench sweeps every phase count from 0 to 6, with the six counts rotated against each other so that a phase measured with the wrong register shows up as a wrong run length. An off-by-one counter gives runs one cycle too long or too short, and treating zero as zero would skip a phase entirely. The bench also targets the ordering cases. A STOP started without waiting for the engine leaves the owned state early. A STOP that loses to a repeated START shows the wrong line pattern. A START that ignores the bus-free hold-off cuts the bus-free run short. A stray request latched while idle ends a later transfer by itself.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SHOLD,
    ST_OWNED,
    ST_PLOW,
    ST_PSETUP,
    ST_PFREE,
    ST_RLOW,
    ST_RSETUP,
    ST_RHOLD
  } cond_state_e;

  // {scl_pull, sda_pull} for each phase; 1 = drive low
  function automatic logic [1:0] line_pulls(input cond_state_e s);
    case (s)
      ST_SHOLD:  return 2'b01;
      ST_OWNED:  return 2'b11;
      ST_PLOW:   return 2'b11;
      ST_PSETUP: return 2'b01;
      ST_RLOW:   return 2'b10;
      ST_RHOLD:  return 2'b01;
      default:   return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/cond_phase_timer.sv
module cond_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // a programmed zero still yields one cycle of phase
  function automatic logic [CW-1:0] phase_len(input logic [CW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= ONE;
    else if (load)       cnt <= phase_len(load_val);
    else if (cnt > ONE)  cnt <= cnt - ONE;
  end

  assign expire = (cnt == ONE);

  // R2
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

  // R4
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == phase_len($past(load_val)));

endmodule

// File: rtl/cond_sticky_flag.sv
module cond_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R7 R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R7 R8
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] t_start_hold,
  input  logic [CW-1:0] t_rs_hold,
  input  logic [CW-1:0] t_rs_setup,
  input  logic [CW-1:0] t_data_setup,
  input  logic [CW-1:0] t_stop_setup,
  input  logic [CW-1:0] t_bus_free,
  input  logic          req_start,
  input  logic          req_stop,
  input  logic          req_rstart,
  input  logic          shifter_idle,
  input  logic          clr_stop,
  input  logic          clr_rstart,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          busy,
  output logic          stop_flag,
  output logic          rstart_flag
);
  cond_state_e   state, state_n;
  logic          pend_start, pend_stop, pend_rs;
  logic          bus_owned, want_start, want_stop, want_rs;
  logic          phase_exp, phase_load;
  logic [CW-1:0] phase_val;
  logic          stop_done, rs_done;

  assign bus_owned  = state inside {ST_SHOLD, ST_OWNED, ST_RLOW, ST_RSETUP, ST_RHOLD};
  assign want_start = pend_start | req_start;
  assign want_stop  = pend_stop | (req_stop & bus_owned);
  assign want_rs    = pend_rs | (req_rstart & bus_owned);

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:   if (want_start) state_n = ST_SHOLD;
      ST_SHOLD:  if (phase_exp) state_n = ST_OWNED;
      ST_OWNED: begin
        if (shifter_idle && want_stop)    state_n = ST_PLOW;
        else if (shifter_idle && want_rs) state_n = ST_RLOW;
      end
      ST_PLOW:   if (phase_exp) state_n = ST_PSETUP;
      ST_PSETUP: if (phase_exp) state_n = ST_PFREE;
      ST_PFREE:  if (phase_exp) state_n = ST_IDLE;
      ST_RLOW:   if (phase_exp) state_n = ST_RSETUP;
      ST_RSETUP: if (phase_exp) state_n = ST_RHOLD;
      ST_RHOLD:  if (phase_exp) state_n = ST_OWNED;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_n)
      ST_SHOLD:         phase_val = t_start_hold;
      ST_PLOW, ST_RLOW: phase_val = t_data_setup;
      ST_PSETUP:        phase_val = t_stop_setup;
      ST_PFREE:         phase_val = t_bus_free;
      ST_RSETUP:        phase_val = t_rs_setup;
      ST_RHOLD:         phase_val = t_rs_hold;
      default:          phase_val = '0;
    endcase
  end

  assign phase_load = (state_n != state);
  assign stop_done  = (state == ST_PSETUP) && (state_n == ST_PFREE);
  assign rs_done    = (state == ST_RHOLD) && (state_n == ST_OWNED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pend_start <= 1'b0;
      pend_stop  <= 1'b0;
      pend_rs    <= 1'b0;
    end else begin
      state      <= state_n;
      pend_start <= (state_n == ST_SHOLD) ? 1'b0 : want_start;
      pend_stop  <= (state_n == ST_PLOW) ? 1'b0 : want_stop;
      pend_rs    <= (state_n == ST_PLOW || state_n == ST_RLOW) ? 1'b0 : want_rs;
    end
  end

  assign {scl_pull, sda_pull} = line_pulls(state);
  assign busy = (state != ST_IDLE);

  cond_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_val),
    .expire   (phase_exp)
  );

  cond_sticky_flag u_stop_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (stop_done),
    .clr_i  (clr_stop),
    .flag_o (stop_flag)
  );

  cond_sticky_flag u_rs_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (rs_done),
    .clr_i  (clr_rstart),
    .flag_o (rstart_flag)
  );

  // R11
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull != $past(scl_pull)) |-> (sda_pull == $past(sda_pull)));

  // R6
  wait_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OWNED && !shifter_idle) |=> state == ST_OWNED);

  // R3
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHOLD && $past(state) != ST_SHOLD) |-> $past(state) == ST_IDLE && !$past(busy));

  // R9
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> !pend_stop && !pend_rs);

  // R7
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> stop_flag && busy && !scl_pull && !sda_pull);

endmodule

// File: tb/tb_i2c_cond_seq.sv
module tb_i2c_cond_seq;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] t_sh, t_rh, t_rsu, t_ds, t_ss, t_bf;
  logic req_start = 0, req_stop = 0, req_rstart = 0;
  logic shifter_idle = 1, clr_stop = 0, clr_rstart = 0;
  logic scl_pull, sda_pull, busy, stop_flag, rstart_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_cond_seq #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .t_start_hold(t_sh), .t_rs_hold(t_rh), .t_rs_setup(t_rsu),
    .t_data_setup(t_ds), .t_stop_setup(t_ss), .t_bus_free(t_bf),
    .req_start(req_start), .req_stop(req_stop), .req_rstart(req_rstart),
    .shifter_idle(shifter_idle), .clr_stop(clr_stop), .clr_rstart(clr_rstart),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy),
    .stop_flag(stop_flag), .rstart_flag(rstart_flag)
  );

  function automatic int el(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic int pat();
    return {29'd0, scl_pull, sda_pull, busy};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // count consecutive negedge samples matching p; ends on first mismatch
  task automatic run_len(input int p, output int n);
    n = 0;
    while (pat() == p && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic strobe(input int which);
    case (which)
      0: req_start = 1;
      1: req_stop = 1;
      default: req_rstart = 1;
    endcase
    @(negedge clk);
    req_start = 0; req_stop = 0; req_rstart = 0;
  endtask

  task automatic do_start();
    int n;
    strobe(0);
    run_len(3'b011, n);
    chk(n == el(t_sh), "R2 start hold length", n, el(t_sh));
    chk(pat() == 3'b111, "R2 owned after start", pat(), 3'b111);
  endtask

  task automatic do_rs();
    int n;
    strobe(2);
    run_len(3'b101, n);
    chk(n == el(t_ds), "R5 rs data setup", n, el(t_ds));
    run_len(3'b001, n);
    chk(n == el(t_rsu), "R5 rs setup", n, el(t_rsu));
    run_len(3'b011, n);
    chk(n == el(t_rh), "R5 rs hold", n, el(t_rh));
    chk(pat() == 3'b111, "R5 owned after rs", pat(), 3'b111);
    chk(rstart_flag == 1'b1, "R8 rstart flag set", rstart_flag, 1);
  endtask

  task automatic finish_stop(input bit from_strobe);
    int n;
    if (from_strobe) strobe(1);
    run_len(3'b111, n);
    chk(n == el(t_ds), "R4 stop data setup", n, el(t_ds));
    run_len(3'b011, n);
    chk(n == el(t_ss), "R4 stop setup", n, el(t_ss));
    chk(stop_flag == 1'b1, "R7 stop flag set", stop_flag, 1);
    run_len(3'b001, n);
    chk(n == el(t_bf), "R3 bus free length", n, el(t_bf));
    chk(pat() == 3'b000, "R4 idle after stop", pat(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    t_sh = 3; t_rh = 2; t_rsu = 4; t_ds = 2; t_ss = 3; t_bf = 5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pat() == 0, "R1 reset lines", pat(), 0);
    chk({stop_flag, rstart_flag} == 2'b00, "R1 reset flags", {stop_flag, rstart_flag}, 0);

    // R9: stray requests while idle
    strobe(1); strobe(2);
    repeat (4) @(negedge clk);
    chk(pat() == 0, "R9 idle unaffected", pat(), 0);
    chk({stop_flag, rstart_flag} == 2'b00, "R9 flags unaffected", {stop_flag, rstart_flag}, 0);
    do_start();
    repeat (12) @(negedge clk);
    chk(pat() == 3'b111, "R9 no latched stop", pat(), 3'b111);
    finish_stop(1);
    clr_stop = 1; @(negedge clk); clr_stop = 0;
    chk(stop_flag == 0, "R7 stop flag cleared", stop_flag, 0);

    // R6 and R10: both pending while engine busy
    do_start();
    shifter_idle = 0;
    strobe(2); strobe(1);
    repeat (10) @(negedge clk);
    chk(pat() == 3'b111, "R6 waits for engine", pat(), 3'b111);
    shifter_idle = 1;
    @(negedge clk);
    finish_stop(0);
    chk(rstart_flag == 0, "R10 rs discarded", rstart_flag, 0);
    clr_stop = 1; @(negedge clk); clr_stop = 0;

    // R7: set beats a simultaneous clear
    do_start();
    clr_stop = 1;
    strobe(1);
    run_len(3'b111, n);
    run_len(3'b011, n);
    chk(stop_flag == 1, "R7 set wins over clear", stop_flag, 1);
    @(negedge clk);
    chk(stop_flag == 0, "R7 held clear acts next", stop_flag, 0);
    clr_stop = 0;
    run_len(3'b001, n);

    // R3: START arriving during bus-free
    do_start();
    strobe(1);
    run_len(3'b111, n);
    run_len(3'b011, n);
    req_start = 1;
    run_len(3'b001, n);
    req_start = 0;
    chk(n == el(t_bf), "R3 bus free not cut", n, el(t_bf));
    run_len(3'b000, n);
    chk(n == 1, "R3 one released cycle", n, 1);
    run_len(3'b011, n);
    chk(n == el(t_sh), "R3 held start runs", n, el(t_sh));
    finish_stop(1);
    clr_stop = 1; @(negedge clk); clr_stop = 0;

    // sweep of counts 0..6, rotated across the six phases
    for (int v = 0; v < 7; v++) begin
      t_sh = CW'(v); t_rh = CW'((v + 1) % 7); t_rsu = CW'((v + 3) % 7);
      t_ds = CW'((v + 5) % 7); t_ss = CW'((v + 2) % 7); t_bf = CW'((v + 4) % 7);
      do_start();
      do_rs();
      clr_rstart = 1; @(negedge clk); clr_rstart = 0;
      chk(rstart_flag == 0, "R8 rstart flag cleared", rstart_flag, 0);
      do_rs();
      clr_rstart = 1; @(negedge clk); clr_rstart = 0;
      finish_stop(1);
      clr_stop = 1; @(negedge clk); clr_stop = 0;
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule